// File: doc/BRIEF.md
# Thermal Input Fan Boost Override

This block sits in the fan path, between the fan-speed controller and the PWM waveform generator. It watches an external active-low thermal input. When that input is pulled low and boost is enabled, it raises the fan duty to full scale, but only if the fan is already turning. In manual mode the fan counts as turning when the programmed duty is non-zero. In automatic mode it counts as turning when the measured temperature is strictly above the minimum-temperature threshold. In every other case the duty requested for the current mode passes through unchanged.

The thermal input first goes through a two-flop synchronizer. A saturating timer counts the clock cycles during which the synchronized input is low, so firmware can measure how long the system has been throttled. A single-cycle read strobe clears the timer. Firmware samples `assert_time` in the same cycle as the strobe.

Top module: `fanbst_override`

## Requirements
- R1: While `rst` is high, `duty_out` is 0x00 and `assert_time` is 0 after the next rising edge.
- R2: When the override is not engaged, `duty_out` takes, one cycle later, the requested duty: `manual_duty` when `mode_auto`=0 and `auto_duty` when `mode_auto`=1.
- R3: In manual mode (`mode_auto`=0), with `boost_en`=1, the synchronized input low and `manual_duty` non-zero (including 0x01), `duty_out` is 0xFF.
- R4: In manual mode with `manual_duty`=0x00, a low thermal input has no effect and `duty_out` stays 0x00.
- R5: In automatic mode with `boost_en`=1 and the input low, `duty_out` is 0xFF when `temp` > `tmin` (unsigned). When `temp` <= `tmin`, including equality, `duty_out` equals `auto_duty`. `manual_duty` plays no part in this decision.
- R6: With `boost_en`=0, a low thermal input never changes `duty_out`.
- R7: A level change on `therm_n` reaches `duty_out` at the third rising edge after it. After two edges the old value is still shown. This holds both for applying and for removing the override.
- R8: `assert_time` rises by exactly 1 per cycle while the synchronized input is low, and holds while it is high.
- R9: `assert_time` saturates at 2^CNT_W-1 and stays there while the input remains low.
- R10: A cycle with `timer_rd`=1 sets `assert_time` to 0 at the next edge, even while the input is low. Counting resumes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_n | input | 1 | Asynchronous active-low thermal input |
| boost_en | input | 1 | Enables the full-speed override |
| mode_auto | input | 1 | 1 = automatic fan control, 0 = manual |
| manual_duty | input | DUTY_W | Programmed manual duty |
| auto_duty | input | DUTY_W | Duty requested by the automatic controller |
| temp | input | TEMP_W | Current temperature, unsigned |
| tmin | input | TEMP_W | Minimum-temperature threshold, unsigned |
| timer_rd | input | 1 | Read strobe that clears the assertion timer |
| duty_out | output | DUTY_W | Effective duty to the PWM generator |
| assert_time | output | CNT_W | Cycles the thermal input has been held low |

## Verification
If the synchronizer state is wrong, the override edges move away from the third edge after a pin change. If the qualification is wrong, full scale appears with zero manual duty or at a temperature equal to the threshold, and the requested duty vanishes in that cycle. Because `duty_out` is registered, any fault in the duty path shows one cycle after the inputs that expose it. A fault in the timer shows as an off-by-one count after a timed low pulse, as wrap-around past the maximum, or as a non-zero value after a read strobe. Each of these can be seen at `assert_time` on the cycle after the event.

// File: rtl/fanbst_pkg.sv
package fanbst_pkg;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } fan_mode_e;

    typedef enum logic {
        SRC_REQUEST = 1'b0,
        SRC_FULL    = 1'b1
    } duty_src_e;

    typedef struct packed {
        logic      spinning;
        duty_src_e src;
    } boost_qual_t;

    // Fan counts as already turning: judged per mode.
    function automatic logic fan_spinning(fan_mode_e mode, logic man_nonzero, logic above_min);
        logic r;
        if (mode == MODE_AUTO) r = above_min;
        else                   r = man_nonzero;
        return r;
    endfunction

    function automatic duty_src_e pick_source(logic en, logic pin_low, logic spinning);
        duty_src_e s;
        if (en && pin_low && spinning) s = SRC_FULL;
        else                           s = SRC_REQUEST;
        return s;
    endfunction

endpackage

// File: rtl/fanbst_sync.sv
module fanbst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fanbst_qual.sv
module fanbst_qual
    import fanbst_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int TEMP_W = 8
) (
    input  fan_mode_e          mode,
    input  logic [DUTY_W-1:0]  manual_duty,
    input  logic [TEMP_W-1:0]  temp,
    input  logic [TEMP_W-1:0]  tmin,
    input  logic               boost_en,
    input  logic               pin_low,
    output boost_qual_t        qual
);
    logic man_nonzero;
    logic above_min;

    always_comb begin
        man_nonzero   = |manual_duty;
        above_min     = (temp > tmin);
        qual.spinning = fan_spinning(mode, man_nonzero, above_min);
        qual.src      = pick_source(boost_en, pin_low, qual.spinning);
    end
endmodule

// File: rtl/fanbst_duty_mux.sv
module fanbst_duty_mux
    import fanbst_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  fan_mode_e         mode,
    input  logic [DUTY_W-1:0] manual_duty,
    input  logic [DUTY_W-1:0] auto_duty,
    input  boost_qual_t       qual,
    output logic [DUTY_W-1:0] duty_q
);
    localparam logic [DUTY_W-1:0] FULL_SCALE = {DUTY_W{1'b1}};

    logic [DUTY_W-1:0] req_duty;
    logic [DUTY_W-1:0] nxt_duty;

    always_comb begin
        req_duty = (mode == MODE_AUTO) ? auto_duty : manual_duty;
        case (qual.src)
            SRC_FULL: nxt_duty = FULL_SCALE;
            default:  nxt_duty = req_duty;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) duty_q <= '0;
        else     duty_q <= nxt_duty;
    end
endmodule

// File: rtl/fanbst_timer.sv
module fanbst_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_low,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)                            cnt <= '0;
        else if (clr)                       cnt <= '0;
        else if (pin_low && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fanbst_override.sv
module fanbst_override
    import fanbst_pkg::*;
#(
    parameter int DUTY_W    = 8,
    parameter int TEMP_W    = 8,
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              therm_n,
    input  logic              boost_en,
    input  logic              mode_auto,
    input  logic [DUTY_W-1:0] manual_duty,
    input  logic [DUTY_W-1:0] auto_duty,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] tmin,
    input  logic              timer_rd,
    output logic [DUTY_W-1:0] duty_out,
    output logic [CNT_W-1:0]  assert_time
);
    logic        therm_n_s;
    logic        pin_low_s;
    fan_mode_e   mode;
    boost_qual_t qual;

    assign mode      = fan_mode_e'(mode_auto);
    assign pin_low_s = ~therm_n_s;

    fanbst_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (therm_n),
        .q   (therm_n_s)
    );

    fanbst_qual #(.DUTY_W(DUTY_W), .TEMP_W(TEMP_W)) u_qual (
        .mode        (mode),
        .manual_duty (manual_duty),
        .temp        (temp),
        .tmin        (tmin),
        .boost_en    (boost_en),
        .pin_low     (pin_low_s),
        .qual        (qual)
    );

    fanbst_duty_mux #(.DUTY_W(DUTY_W)) u_mux (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .manual_duty (manual_duty),
        .auto_duty   (auto_duty),
        .qual        (qual),
        .duty_q      (duty_out)
    );

    fanbst_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .pin_low (pin_low_s),
        .clr     (timer_rd),
        .cnt     (assert_time)
    );
endmodule

// File: rtl/fanbst_override_chk.sv
module fanbst_override_chk #(
    parameter int DUTY_W = 8,
    parameter int TEMP_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pin_low,
    input logic              boost_en,
    input logic              mode_auto,
    input logic [DUTY_W-1:0] manual_duty,
    input logic [DUTY_W-1:0] auto_duty,
    input logic [TEMP_W-1:0] temp,
    input logic [TEMP_W-1:0] tmin,
    input logic              timer_rd,
    input logic [DUTY_W-1:0] duty_out,
    input logic [CNT_W-1:0]  assert_time
);
    localparam logic [CNT_W-1:0]  TMAX = {CNT_W{1'b1}};
    localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

    logic              spin;
    logic [DUTY_W-1:0] req;
    assign spin = mode_auto ? (temp > tmin) : (manual_duty != '0);
    assign req  = mode_auto ? auto_duty : manual_duty;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (duty_out == '0 && assert_time == '0));

    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        !(boost_en && pin_low && spin) |=> duty_out == $past(req));

    assert_boost_R3: assert property (@(posedge clk) disable iff (rst)
        (boost_en && pin_low && spin) |=> duty_out == FULL);

    assert_zero_manual_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_auto && manual_duty == '0) |=> duty_out == '0);

    assert_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !boost_en |=> duty_out == $past(req));

    assert_timer_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!timer_rd && pin_low && assert_time != TMAX) |=> assert_time == $past(assert_time) + 1'b1);

    assert_timer_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!timer_rd && !pin_low) |=> $stable(assert_time));

    assert_timer_sat_R9: assert property (@(posedge clk) disable iff (rst)
        (!timer_rd && assert_time == TMAX) |=> assert_time == TMAX);

    assert_timer_clear_R10: assert property (@(posedge clk) disable iff (rst)
        timer_rd |=> assert_time == '0);
endmodule

bind fanbst_override fanbst_override_chk #(
    .DUTY_W (DUTY_W),
    .TEMP_W (TEMP_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_low     (pin_low_s),
    .boost_en    (boost_en),
    .mode_auto   (mode_auto),
    .manual_duty (manual_duty),
    .auto_duty   (auto_duty),
    .temp        (temp),
    .tmin        (tmin),
    .timer_rd    (timer_rd),
    .duty_out    (duty_out),
    .assert_time (assert_time)
);

// File: tb/fanbst_override_tb.sv
module fanbst_override_tb;
    localparam int CW   = 6;
    localparam int TMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          therm_n, boost_en, mode_auto, timer_rd;
    logic [7:0]    manual_duty, auto_duty, temp, tmin;
    logic [7:0]    duty_out;
    logic [CW-1:0] assert_time;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    int  pos_cnt = 0;
    bit  done   = 1'b0;

    typedef struct {
        int    due;
        bit    is_time;
        int    exp;
        string req;
    } exp_t;
    exp_t q[$];
    exp_t it;

    fanbst_override #(.DUTY_W(8), .TEMP_W(8), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .therm_n(therm_n), .boost_en(boost_en),
        .mode_auto(mode_auto), .manual_duty(manual_duty), .auto_duty(auto_duty),
        .temp(temp), .tmin(tmin), .timer_rd(timer_rd),
        .duty_out(duty_out), .assert_time(assert_time)
    );

    always #5 clk = ~clk;
    always @(posedge clk) pos_cnt <= pos_cnt + 1;

    // Monitor: pops due expectations and compares away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= pos_cnt) begin
            it = q.pop_front();
            n_cmp++;
            if (it.is_time) begin
                if (int'(assert_time) != it.exp) begin
                    n_bad++;
                    $display("FAIL %s assert_time actual=%0d expected=%0d", it.req, assert_time, it.exp);
                end
            end else if (int'(duty_out) != it.exp) begin
                n_bad++;
                $display("FAIL %s duty_out actual=0x%02h expected=0x%02h", it.req, duty_out, it.exp);
            end
        end
    end

    task automatic push(int lat, bit is_t, int e, string r);
        exp_t x;
        x.due = pos_cnt + lat; x.is_time = is_t; x.exp = e; x.req = r;
        q.push_back(x);
    endtask

    // Driver: apply inputs, expect duty after lat edges.
    task automatic step(bit pin_n, bit en, bit au, logic [7:0] man, logic [7:0] adu,
                        logic [7:0] tp, logic [7:0] tm, int lat, int e, string r);
        @(negedge clk);
        therm_n = pin_n; boost_en = en; mode_auto = au;
        manual_duty = man; auto_duty = adu; temp = tp; tmin = tm;
        push(lat, 1'b0, e, r);
        repeat (lat) @(negedge clk);
    endtask

    task automatic time_check(int e, string r);
        push(1, 1'b1, e, r);
        @(negedge clk);
    endtask

    task automatic clear_timer();
        @(negedge clk); timer_rd = 1'b1;
        @(negedge clk); timer_rd = 1'b0;
    endtask

    task automatic low_pulse(int n);
        @(negedge clk); therm_n = 1'b0;
        repeat (n) @(negedge clk);
        therm_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; therm_n = 1'b1; boost_en = 1'b0; mode_auto = 1'b0; timer_rd = 1'b0;
        manual_duty = 8'h00; auto_duty = 8'h00; temp = 8'd0; tmin = 8'd0;
        repeat (2) @(negedge clk);
        manual_duty = 8'h77; therm_n = 1'b0;
        push(1, 1'b0, 0, "R1");
        push(1, 1'b1, 0, "R1");
        @(negedge clk);
        therm_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Manual mode pass-through and boost with latency
        step(1, 1, 0, 8'h40, 8'h00, 8'd0, 8'd0, 1, 8'h40, "R2");
        step(0, 1, 0, 8'h40, 8'h00, 8'd0, 8'd0, 2, 8'h40, "R7 apply old");
        step(0, 1, 0, 8'h40, 8'h00, 8'd0, 8'd0, 1, 8'hFF, "R3/R7 apply");
        step(1, 1, 0, 8'h40, 8'h00, 8'd0, 8'd0, 2, 8'hFF, "R7 remove old");
        step(1, 1, 0, 8'h40, 8'h00, 8'd0, 8'd0, 1, 8'h40, "R7 remove");
        // Zero manual duty: no effect; duty 0x01 boundary
        step(0, 1, 0, 8'h00, 8'h00, 8'd0, 8'd0, 3, 8'h00, "R4");
        step(0, 1, 0, 8'h01, 8'h00, 8'd0, 8'd0, 1, 8'hFF, "R3 min duty");
        step(0, 0, 0, 8'h01, 8'h00, 8'd0, 8'd0, 1, 8'h01, "R6");
        // Automatic mode
        step(0, 1, 1, 8'h00, 8'h30, 8'd50, 8'd40, 1, 8'hFF, "R5 above");
        step(0, 1, 1, 8'h00, 8'h30, 8'd40, 8'd40, 1, 8'h30, "R5 equal");
        step(0, 1, 1, 8'h99, 8'h30, 8'd30, 8'd40, 1, 8'h30, "R5 below");
        step(0, 1, 1, 8'h00, 8'h30, 8'd41, 8'd40, 1, 8'hFF, "R5 just above");
        step(0, 0, 1, 8'h00, 8'h30, 8'd90, 8'd40, 1, 8'h30, "R6 auto");
        step(1, 1, 1, 8'h55, 8'h22, 8'd90, 8'd40, 3, 8'h22, "R2 auto");

        // Timer
        clear_timer();
        time_check(0, "R10 clear");
        low_pulse(5);
        time_check(5, "R8 count");
        repeat (10) @(negedge clk);
        time_check(5, "R8 hold");
        low_pulse(7);
        time_check(12, "R8 accumulate");
        clear_timer();
        low_pulse(80);
        time_check(TMAX, "R9 saturate");
        @(negedge clk); therm_n = 1'b0;
        repeat (6) @(negedge clk);
        timer_rd = 1'b1;
        push(1, 1'b1, 0, "R10 clear while low");
        @(negedge clk); timer_rd = 1'b0;
        repeat (3) @(negedge clk);
        time_check(4, "R10 resume");
        therm_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule